// File: doc/BRIEF.md
# Execute Redirect Squash Arbiter

This block sits at the end of the execute stage of an out-of-order core. Each cycle it looks at up to `LANES` instructions that have just finished executing. For every hardware thread it decides whether to send a squash and redirect request toward the commit stage.

Three causes can start a redirect:
- a branch whose outcome differs from its prediction;
- a memory-order violation reported by the load/store unit;
- a load that the memory system refused and that has not been serviced yet.

Each cause has its own rule for the restart PC and for whether the offending instruction itself is thrown away. A thread gets at most one redirect per cycle. Instructions that were already squashed upstream are retired quietly as done.

The request for each thread is registered, so it appears one cycle after the executed instructions are presented. Four running counters report:
- wrongly predicted-taken branches;
- wrongly predicted-not-taken branches;
- violation squashes;
- skipped squashed instructions.

Top module: `exec_redirect_arb`

## Requirements
- R1: A thread raises at most one redirect per cycle. Within the winning cause, the lowest-numbered lane belonging to that thread supplies the fields. The per-thread choice starts fresh every cycle, so a redirect in one cycle does not block a redirect in the next.
- R2: Within a thread the causes rank as follows: any mispredicted branch wins over any memory-order violation, and a violation wins over a blocked load.
- R3: A mispredict redirect carries the branch's sequence number, restarts at its next PC, and has include-self = 0 and mispredict = 1. Branch-taken is 1 exactly when next PC differs from PC + `ISIZE` (default 4).
- R4: A violation redirect carries the instruction's sequence number and restarts at its next PC, with include-self, mispredict and branch-taken all 0. The violation counter rises by one per violation redirect.
- R5: A blocked-load redirect restarts at the load's own PC with include-self = 1 and mispredict = branch-taken = 0. It records the load's sequence number as handled for that thread. A later blocked load from that thread fires only if its 16-bit sequence number is newer than the handled one under modulo-2^16 comparison, that is (new − handled) mod 2^16 is nonzero and below 2^15.
- R6: Every mispredict redirect increments exactly one counter: the predicted-taken counter when the branch's predicted-taken flag is 1, otherwise the predicted-not-taken counter.
- R7: A valid lane with its squashed flag set raises no redirect whatever its other flags say. It sets its bit in the skip acknowledge one cycle later and adds one to the skip counter.
- R8: Redirect outputs are registered and reflect the lanes presented one cycle earlier. When a thread has no redirect, all of its output fields are 0. Reset clears every output and counter.
- R9: Threads are decided independently: redirects for different threads in the same cycle are all reported together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_valid | input | LANES | Lane holds an executed instruction |
| ex_tid | input | LANES*TW | Thread id per lane |
| ex_seq | input | LANES*SEQW | Sequence number per lane |
| ex_pc | input | LANES*PCW | Instruction PC per lane |
| ex_npc | input | LANES*PCW | Resolved next PC per lane |
| ex_mispred | input | LANES | Branch outcome disagreed with prediction |
| ex_pred_taken | input | LANES | Branch had been predicted taken |
| ex_squashed | input | LANES | Instruction already squashed upstream |
| ex_viol | input | LANES | Memory-order violation flagged on this instruction |
| ex_ldblk | input | LANES | Load refused by the memory system |
| sq_valid | output | NT | Redirect request per thread |
| sq_seq | output | NT*SEQW | Squash sequence number per thread |
| sq_pc | output | NT*PCW | Restart PC per thread |
| sq_incl | output | NT | Squash includes the named instruction |
| sq_taken | output | NT | Mispredicted branch was actually taken |
| sq_mispred | output | NT | Redirect caused by a branch mispredict |
| skip_ack | output | LANES | Lane was a squashed instruction, retired as done |
| cnt_pt_wrong | output | CW | Mispredicts that had been predicted taken |
| cnt_pnt_wrong | output | CW | Mispredicts that had been predicted not taken |
| cnt_viol | output | CW | Violation redirects |
| cnt_skip | output | CW | Squashed instructions skipped |

## Verification
The bench first puts a violation in lane 0 and a mispredict in lane 1 of one thread. An arbiter that ranks by lane instead of by cause would report the violation. Two mispredicts in one thread in one cycle catch a design that lets the later lane overwrite the earlier one.

The blocked-load sequence resends the same load, then a wrapped-around newer load, then an older one. A plain magnitude compare would miss the wrapped load, and a missing handled flag would fire twice. A blocked load that loses to a violation is presented again the next cycle. This shows that losing does not mark it handled.

Squashed lanes that carry mispredict flags, and invalid lanes that carry any flag, must leave the redirect outputs at zero.

// File: rtl/exec_redirect_arb.sv
module exec_redirect_arb #(
  parameter int NT    = 2,
  parameter int LANES = 2,
  parameter int PCW   = 32,
  parameter int SEQW  = 16,
  parameter int ISIZE = 4,
  parameter int CW    = 16,
  localparam int TW   = (NT > 1) ? $clog2(NT) : 1,
  localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      ex_valid,
  input  logic [LANES*TW-1:0]   ex_tid,
  input  logic [LANES*SEQW-1:0] ex_seq,
  input  logic [LANES*PCW-1:0]  ex_pc,
  input  logic [LANES*PCW-1:0]  ex_npc,
  input  logic [LANES-1:0]      ex_mispred,
  input  logic [LANES-1:0]      ex_pred_taken,
  input  logic [LANES-1:0]      ex_squashed,
  input  logic [LANES-1:0]      ex_viol,
  input  logic [LANES-1:0]      ex_ldblk,
  output logic [NT-1:0]         sq_valid,
  output logic [NT*SEQW-1:0]    sq_seq,
  output logic [NT*PCW-1:0]     sq_pc,
  output logic [NT-1:0]         sq_incl,
  output logic [NT-1:0]         sq_taken,
  output logic [NT-1:0]         sq_mispred,
  output logic [LANES-1:0]      skip_ack,
  output logic [CW-1:0]         cnt_pt_wrong,
  output logic [CW-1:0]         cnt_pnt_wrong,
  output logic [CW-1:0]         cnt_viol,
  output logic [CW-1:0]         cnt_skip
);

  function automatic logic newer(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
    logic [SEQW-1:0] d;
    d = a - b;
    return (d != '0) && !d[SEQW-1];
  endfunction

  logic [TW-1:0]   l_tid [LANES];
  logic [SEQW-1:0] l_seq [LANES];
  logic [PCW-1:0]  l_pc  [LANES];
  logic [PCW-1:0]  l_npc [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign l_tid[g] = ex_tid[g*TW +: TW];
    assign l_seq[g] = ex_seq[g*SEQW +: SEQW];
    assign l_pc[g]  = ex_pc[g*PCW +: PCW];
    assign l_npc[g] = ex_npc[g*PCW +: PCW];
  end

  logic [LANES-1:0] live, skip;
  assign live = ex_valid & ~ex_squashed;
  assign skip = ex_valid & ex_squashed;

  logic [NT-1:0]   hnd_v;
  logic [SEQW-1:0] hnd_seq [NT];

  logic [NT-1:0]   nx_v, nx_incl, nx_tk, nx_mis, nx_seth;
  logic [NT-1:0]   w_pt, w_pnt, w_vi;
  logic [SEQW-1:0] nx_seq [NT];
  logic [PCW-1:0]  nx_pc  [NT];

  for (genvar t = 0; t < NT; t++) begin : g_thr
    logic br_hit, vi_hit, lb_hit;
    logic [LW-1:0] br_l, vi_l, lb_l;
    logic v_o, incl_o, tk_o, mis_o, seth_o;
    logic [SEQW-1:0] seq_o;
    logic [PCW-1:0]  pc_o;

    always_comb begin
      br_hit = 1'b0; vi_hit = 1'b0; lb_hit = 1'b0;
      br_l = '0; vi_l = '0; lb_l = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (live[l] && l_tid[l] == TW'(t)) begin
          if (ex_mispred[l]) begin br_hit = 1'b1; br_l = LW'(l); end
          if (ex_viol[l])    begin vi_hit = 1'b1; vi_l = LW'(l); end
          if (ex_ldblk[l] && (!hnd_v[t] || newer(l_seq[l], hnd_seq[t]))) begin
            lb_hit = 1'b1; lb_l = LW'(l);
          end
        end
      end
    end

    always_comb begin
      v_o = 1'b0; incl_o = 1'b0; tk_o = 1'b0; mis_o = 1'b0; seth_o = 1'b0;
      seq_o = '0; pc_o = '0;
      if (br_hit) begin
        v_o   = 1'b1;
        mis_o = 1'b1;
        seq_o = l_seq[br_l];
        pc_o  = l_npc[br_l];
        tk_o  = l_npc[br_l] != (l_pc[br_l] + PCW'(ISIZE));
      end else if (vi_hit) begin
        v_o   = 1'b1;
        seq_o = l_seq[vi_l];
        pc_o  = l_npc[vi_l];
      end else if (lb_hit) begin
        v_o    = 1'b1;
        incl_o = 1'b1;
        seth_o = 1'b1;
        seq_o  = l_seq[lb_l];
        pc_o   = l_pc[lb_l];
      end
    end

    assign nx_v[t]    = v_o;
    assign nx_incl[t] = incl_o;
    assign nx_tk[t]   = tk_o;
    assign nx_mis[t]  = mis_o;
    assign nx_seth[t] = seth_o;
    assign nx_seq[t]  = seq_o;
    assign nx_pc[t]   = pc_o;
    assign w_pt[t]    = br_hit && ex_pred_taken[br_l];
    assign w_pnt[t]   = br_hit && !ex_pred_taken[br_l];
    assign w_vi[t]    = !br_hit && vi_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_valid      <= '0;
      sq_seq        <= '0;
      sq_pc         <= '0;
      sq_incl       <= '0;
      sq_taken      <= '0;
      sq_mispred    <= '0;
      skip_ack      <= '0;
      cnt_pt_wrong  <= '0;
      cnt_pnt_wrong <= '0;
      cnt_viol      <= '0;
      cnt_skip      <= '0;
      hnd_v         <= '0;
      for (int t = 0; t < NT; t++) hnd_seq[t] <= '0;
    end else begin
      sq_valid   <= nx_v;
      sq_incl    <= nx_incl;
      sq_taken   <= nx_tk;
      sq_mispred <= nx_mis;
      skip_ack   <= skip;
      for (int t = 0; t < NT; t++) begin
        sq_seq[t*SEQW +: SEQW] <= nx_seq[t];
        sq_pc[t*PCW +: PCW]    <= nx_pc[t];
        if (nx_seth[t]) begin
          hnd_v[t]   <= 1'b1;
          hnd_seq[t] <= nx_seq[t];
        end
      end
      cnt_pt_wrong  <= cnt_pt_wrong  + CW'($countones(w_pt));
      cnt_pnt_wrong <= cnt_pnt_wrong + CW'($countones(w_pnt));
      cnt_viol      <= cnt_viol      + CW'($countones(w_vi));
      cnt_skip      <= cnt_skip      + CW'($countones(skip));
    end
  end

endmodule

// File: rtl/exec_redirect_arb_chk.sv
module exec_redirect_arb_chk #(
  parameter int NT    = 2,
  parameter int LANES = 2,
  parameter int CW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] ex_valid,
  input logic [LANES-1:0] ex_squashed,
  input logic [NT-1:0]    sq_valid,
  input logic [NT-1:0]    sq_incl,
  input logic [NT-1:0]    sq_taken,
  input logic [NT-1:0]    sq_mispred,
  input logic [LANES-1:0] skip_ack,
  input logic [CW-1:0]    cnt_pt_wrong,
  input logic [CW-1:0]    cnt_pnt_wrong,
  input logic [CW-1:0]    cnt_viol,
  input logic [CW-1:0]    cnt_skip
);

  // R5
  incl_excl_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_incl & (sq_mispred | sq_taken)) == '0);

  // R8
  idle_fields_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sq_incl | sq_mispred | sq_taken) & ~sq_valid) == '0);

  // R8
  no_input_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(|ex_valid) |-> (sq_valid == '0));

  // R9
  redirect_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sq_valid) <= $past($countones(ex_valid & ~ex_squashed)));

  // R6
  mispred_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(cnt_pt_wrong + cnt_pnt_wrong - $past(cnt_pt_wrong) - $past(cnt_pnt_wrong))
      == CW'($countones(sq_valid & sq_mispred)));

  // R4
  viol_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(cnt_viol - $past(cnt_viol)) == CW'($countones(sq_valid & ~sq_mispred & ~sq_incl)));

  // R7
  skip_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(cnt_skip - $past(cnt_skip)) == CW'($countones(skip_ack)));

  // R7
  skip_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_ack & ~$past(ex_valid & ex_squashed)) == '0);

endmodule

bind exec_redirect_arb exec_redirect_arb_chk #(
  .NT(NT), .LANES(LANES), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ex_valid(ex_valid), .ex_squashed(ex_squashed),
  .sq_valid(sq_valid), .sq_incl(sq_incl), .sq_taken(sq_taken),
  .sq_mispred(sq_mispred), .skip_ack(skip_ack), .cnt_pt_wrong(cnt_pt_wrong),
  .cnt_pnt_wrong(cnt_pnt_wrong), .cnt_viol(cnt_viol), .cnt_skip(cnt_skip)
);

// File: tb/tb_exec_redirect_arb.sv
module tb_exec_redirect_arb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2, L = 2, TW = 1, SEQW = 16, PCW = 32, CW = 16, ISZ = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [L-1:0]      ex_valid, ex_mispred, ex_pred_taken, ex_squashed, ex_viol, ex_ldblk;
  logic [L*TW-1:0]   ex_tid;
  logic [L*SEQW-1:0] ex_seq;
  logic [L*PCW-1:0]  ex_pc, ex_npc;
  logic [NT-1:0]     sq_valid, sq_incl, sq_taken, sq_mispred;
  logic [NT*SEQW-1:0] sq_seq;
  logic [NT*PCW-1:0] sq_pc;
  logic [L-1:0]      skip_ack;
  logic [CW-1:0]     cnt_pt_wrong, cnt_pnt_wrong, cnt_viol, cnt_skip;

  exec_redirect_arb dut (.*);

  typedef struct packed {
    logic [NT-1:0] v, incl, tk, mis;
    logic [NT*SEQW-1:0] seq;
    logic [NT*PCW-1:0] pc;
    logic [L-1:0] skip;
    logic [CW-1:0] pt, pnt, vi, sk;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int n_chk = 0, n_bad = 0;

  logic s_v[L], s_mp[L], s_pt[L], s_sq[L], s_vi[L], s_lb[L];
  int   s_tid[L];
  logic [SEQW-1:0] s_seq[L];
  logic [PCW-1:0]  s_pc[L], s_npc[L];
  logic            m_hv[NT];
  logic [SEQW-1:0] m_hs[NT];
  logic [CW-1:0]   m_pt = 0, m_pnt = 0, m_vi = 0, m_sk = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clr();
    for (int l = 0; l < L; l++) begin
      s_v[l] = 0; s_mp[l] = 0; s_pt[l] = 0; s_sq[l] = 0; s_vi[l] = 0; s_lb[l] = 0;
      s_tid[l] = 0; s_seq[l] = 0; s_pc[l] = 0; s_npc[l] = 0;
    end
  endtask

  task automatic put(int l, int tid, logic [SEQW-1:0] seq, logic [PCW-1:0] pc,
                     logic [PCW-1:0] npc, logic mp, logic pt, logic sq, logic vi, logic lb);
    s_v[l] = 1; s_tid[l] = tid; s_seq[l] = seq; s_pc[l] = pc; s_npc[l] = npc;
    s_mp[l] = mp; s_pt[l] = pt; s_sq[l] = sq; s_vi[l] = vi; s_lb[l] = lb;
  endtask

  function automatic logic newer(logic [SEQW-1:0] a, logic [SEQW-1:0] b);
    logic [SEQW-1:0] d;
    d = a - b;
    return (d != 0) && !d[SEQW-1];
  endfunction

  // driver: applies staged lanes for one cycle and queues the expected result
  task automatic step(string tag);
    exp_t e;
    e = '0;
    for (int l = 0; l < L; l++) begin
      ex_valid[l] = s_v[l]; ex_mispred[l] = s_mp[l]; ex_pred_taken[l] = s_pt[l];
      ex_squashed[l] = s_sq[l]; ex_viol[l] = s_vi[l]; ex_ldblk[l] = s_lb[l];
      ex_tid[l*TW +: TW] = TW'(s_tid[l]);
      ex_seq[l*SEQW +: SEQW] = s_seq[l];
      ex_pc[l*PCW +: PCW] = s_pc[l]; ex_npc[l*PCW +: PCW] = s_npc[l];
      if (s_v[l] && s_sq[l]) begin e.skip[l] = 1; m_sk++; end
    end
    for (int t = 0; t < NT; t++) begin
      int b, w, k;
      b = -1; w = -1; k = -1;
      for (int l = L - 1; l >= 0; l--)
        if (s_v[l] && !s_sq[l] && s_tid[l] == t) begin
          if (s_mp[l]) b = l;
          if (s_vi[l]) w = l;
          if (s_lb[l] && (!m_hv[t] || newer(s_seq[l], m_hs[t]))) k = l;
        end
      if (b >= 0) begin
        e.v[t] = 1; e.mis[t] = 1;
        e.seq[t*SEQW +: SEQW] = s_seq[b]; e.pc[t*PCW +: PCW] = s_npc[b];
        e.tk[t] = (s_npc[b] != s_pc[b] + ISZ);
        if (s_pt[b]) m_pt++; else m_pnt++;
      end else if (w >= 0) begin
        e.v[t] = 1;
        e.seq[t*SEQW +: SEQW] = s_seq[w]; e.pc[t*PCW +: PCW] = s_npc[w];
        m_vi++;
      end else if (k >= 0) begin
        e.v[t] = 1; e.incl[t] = 1;
        e.seq[t*SEQW +: SEQW] = s_seq[k]; e.pc[t*PCW +: PCW] = s_pc[k];
        m_hv[t] = 1; m_hs[t] = s_seq[k];
      end
    end
    e.pt = m_pt; e.pnt = m_pnt; e.vi = m_vi; e.sk = m_sk;
    expq.push_back(e);
    tagq.push_back(tag);
    @(negedge clk);
    ex_valid = '0; ex_squashed = '0; ex_mispred = '0; ex_viol = '0; ex_ldblk = '0;
    clr();
  endtask

  // monitor: compares one queued item per cycle after the registering edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t e;
        string tg;
        e = expq.pop_front();
        tg = tagq.pop_front();
        chk(tg, "sq_valid", 64'(sq_valid), 64'(e.v));
        chk(tg, "sq_seq", 64'(sq_seq), 64'(e.seq));
        chk(tg, "sq_pc", 64'(sq_pc), 64'(e.pc));
        chk(tg, "flags", {52'd0, sq_incl, sq_taken, sq_mispred, skip_ack},
                         {52'd0, e.incl, e.tk, e.mis, e.skip});
        chk(tg, "counters", {cnt_pt_wrong, cnt_pnt_wrong, cnt_viol, cnt_skip},
                            {e.pt, e.pnt, e.vi, e.sk});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    ex_valid = '0; ex_mispred = '0; ex_pred_taken = '0; ex_squashed = '0;
    ex_viol = '0; ex_ldblk = '0; ex_tid = '0; ex_seq = '0; ex_pc = '0; ex_npc = '0;
    for (int t = 0; t < NT; t++) begin m_hv[t] = 0; m_hs[t] = 0; end
    clr();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R8 reset state
    chk("R8", "reset sq_valid", 64'(sq_valid), 64'd0);
    chk("R8", "reset counters", {cnt_pt_wrong, cnt_pnt_wrong, cnt_viol, cnt_skip}, 64'd0);

    // R3 R6 taken mispredict, predicted not taken
    put(0, 0, 16'd10, 32'h1000, 32'h1040, 1, 0, 0, 0, 0); step("R3");
    // R3 R6 not-taken outcome, predicted taken
    put(1, 1, 16'd11, 32'h2000, 32'h2004, 1, 1, 0, 0, 0); step("R6");
    // R1 two mispredicts in one thread: lane 0 wins
    put(0, 0, 16'd20, 32'h3000, 32'h3100, 1, 0, 0, 0, 0);
    put(1, 0, 16'd21, 32'h3004, 32'h3200, 1, 1, 0, 0, 0); step("R1");
    // R1 next cycle redirects again
    put(0, 0, 16'd22, 32'h3008, 32'h300C, 1, 1, 0, 0, 0); step("R1");
    // R2 violation lane 0 loses to mispredict lane 1
    put(0, 1, 16'd30, 32'h4000, 32'h4004, 0, 0, 0, 1, 0);
    put(1, 1, 16'd31, 32'h4004, 32'h4800, 1, 0, 0, 0, 0); step("R2");
    // R4 violation alone
    put(1, 0, 16'd40, 32'h5000, 32'h5004, 0, 0, 0, 1, 0); step("R4");
    // R5 blocked load
    put(0, 0, 16'hFFFE, 32'h6000, 32'h6004, 0, 0, 0, 0, 1); step("R5");
    // R5 same load again: suppressed
    put(0, 0, 16'hFFFE, 32'h6000, 32'h6004, 0, 0, 0, 0, 1); step("R5");
    // R5 wrapped newer load fires
    put(1, 0, 16'h0001, 32'h6100, 32'h6104, 0, 0, 0, 0, 1); step("R5");
    // R5 older load suppressed
    put(0, 0, 16'hFFF0, 32'h6200, 32'h6204, 0, 0, 0, 0, 1); step("R5");
    // R2 blocked load loses to violation, then fires next cycle
    put(0, 1, 16'd50, 32'h7000, 32'h7004, 0, 0, 0, 0, 1);
    put(1, 1, 16'd51, 32'h7004, 32'h7008, 0, 0, 0, 1, 0); step("R2");
    put(0, 1, 16'd50, 32'h7000, 32'h7004, 0, 0, 0, 0, 1); step("R2");
    // R7 squashed lanes with cause flags are skipped
    put(0, 0, 16'd60, 32'h8000, 32'h8800, 1, 0, 1, 1, 1);
    put(1, 1, 16'd61, 32'h8004, 32'h8900, 1, 1, 1, 0, 0); step("R7");
    // R7 squashed earlier lane does not hide live later lane
    put(0, 0, 16'd62, 32'h8100, 32'h8200, 1, 0, 1, 0, 0);
    put(1, 0, 16'd63, 32'h8104, 32'h8300, 1, 0, 0, 0, 0); step("R7");
    // R9 both threads redirect in one cycle
    put(0, 1, 16'd70, 32'h9000, 32'h9004, 0, 0, 0, 1, 0);
    put(1, 0, 16'd71, 32'h9100, 32'h9104, 1, 1, 0, 0, 0); step("R9");
    // R8 invalid lanes with flags do nothing
    ex_mispred = '1; ex_viol = '1; ex_ldblk = '1; ex_seq = '1;
    @(negedge clk);
    ex_mispred = '0; ex_viol = '0; ex_ldblk = '0;
    @(posedge clk); #1;
    chk("R8", "invalid lanes sq_valid", 64'(sq_valid), 64'd0);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule